// File: doc/BRIEF.md
# SGI Group Acceptance Filter

This block sits at the receiving side of one processor's interrupt redistributor. It decides whether a software-generated interrupt (SGI) request should become pending. Each request names an SGI number from 0 to 15. It also carries the class of generation path the sender used and the sender's security state. From these two inputs the block works out which interrupt group the sender is asking for: Group 0, Secure Group 1 or Non-secure Group 1.

The target holds a group bit and a modifier bit for every SGI number, and these two bits give the group it expects. If the sender's group equals the target's group, the pending bit for that SGI is set. If they differ, the request is discarded, with no effect on the pending state. A one-cycle drop event reports the rejected SGI number. Pending bits stay set until a per-SGI clear strobe arrives, which is issued when the interrupt is acknowledged.

The block does not decode routing or affinity. It has no legacy memory-mapped SGI generation and no register bus. The configuration bits are plain inputs, sampled in the cycle of each request.

Top module: `sgi_group_filter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pend` is all zeros, `drop_pulse` is 0 and `drop_intid` is 0.
- R2: The `req_kind` encoding is as follows. 2'b00 asks for Group 0. 2'b01 asks for Group 1 of the sender's own security state. 2'b10 asks for Group 1 of the opposite security state. 2'b11 is reserved, and such a request is always dropped. `req_ns` = 1 means the sender is Non-secure and 0 means Secure.
- R3: The target group of SGI i comes from {`cfg_grp[i]`,`cfg_mod[i]`}. The value 00 means Group 0, 10 means Non-secure Group 1 and 01 means Secure Group 1. The value 11 is reserved and behaves as Non-secure Group 1.
- R4: A request whose group matches the target group sets `pend[req_intid]` at the next clock edge. All other pending bits are left unchanged.
- R5: A request whose group does not match leaves `pend` unchanged. In the next cycle it produces `drop_pulse` = 1 for one cycle, with `drop_intid` equal to the rejected SGI number.
- R6: In any cycle that does not follow a rejected request, `drop_pulse` is 0 and `drop_intid` is 0.
- R7: `clr[i]` clears `pend[i]` at the next edge. A clear aimed at a bit that is not pending has no visible effect.
- R8: An accepted request and a clear for the same SGI in the same cycle leave that SGI pending, because the set wins.
- R9: Each SGI number is judged only against its own configuration bits, so SGIs configured differently accept different request classes in the same run.
- R10: An accepted request for an SGI that is already pending leaves it pending and raises no drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An SGI request is presented this cycle |
| req_kind | input | 2 | Generation path class of the request |
| req_ns | input | 1 | Sender security state, 1 = Non-secure |
| req_intid | input | ID_W | SGI number of the request |
| cfg_grp | input | N_SGI | Per-SGI group bit of the target |
| cfg_mod | input | N_SGI | Per-SGI group modifier bit of the target |
| clr | input | N_SGI | Per-SGI clear strobe, issued on acknowledge |
| pend | output | N_SGI | Pending vector |
| drop_pulse | output | 1 | One-cycle pulse for a rejected request |
| drop_intid | output | ID_W | SGI number of the rejected request, 0 otherwise |

## Verification
An accepted request and a clear strobe for the same SGI number can arrive in the same cycle. Both act on the same pending flop. The bench provokes this with a directed case that acknowledges a pending SGI while a matching request for it arrives. The random phase also raises clear strobes often enough that they overlap with accepted requests on the same number. The bench judges the outcome against its own model, in which the set takes priority, and checks that `pend` still holds the bit one cycle later.

// File: rtl/sgi_filt_pkg.sv
package sgi_filt_pkg;

  typedef enum logic [1:0] {
    CLS_G0   = 2'd0,
    CLS_SG1  = 2'd1,
    CLS_NSG1 = 2'd2,
    CLS_NONE = 2'd3
  } sgi_cls_e;

  localparam logic [1:0] KIND_G0     = 2'b00;
  localparam logic [1:0] KIND_G1_OWN = 2'b01;
  localparam logic [1:0] KIND_G1_ALT = 2'b10;

  // Group a sender asks for, from its path class and security state.
  function automatic sgi_cls_e sender_cls(input logic [1:0] kind, input logic ns);
    sgi_cls_e c;
    case (kind)
      KIND_G0:     c = CLS_G0;
      KIND_G1_OWN: c = ns ? CLS_NSG1 : CLS_SG1;
      KIND_G1_ALT: c = ns ? CLS_SG1 : CLS_NSG1;
      default:     c = CLS_NONE;
    endcase
    return c;
  endfunction

  // Group a target expects, from its group and modifier bits.
  function automatic sgi_cls_e target_cls(input logic grp, input logic mdf);
    sgi_cls_e c;
    if (grp)      c = CLS_NSG1;   // 10 and reserved 11
    else if (mdf) c = CLS_SG1;
    else          c = CLS_G0;
    return c;
  endfunction

endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
  import sgi_filt_pkg::*;
#(
  parameter int N_SGI = 16,
  localparam int ID_W = $clog2(N_SGI)
) (
  input  logic [1:0]      kind,
  input  logic            ns,
  input  logic [ID_W-1:0] intid,
  output sgi_cls_e        cls,
  output logic [N_SGI-1:0] id_vec
);

  always_comb begin
    cls    = sender_cls(kind, ns);
    id_vec = '0;
    id_vec[intid] = 1'b1;
  end

endmodule

// File: rtl/sgi_cfg_decode.sv
module sgi_cfg_decode
  import sgi_filt_pkg::*;
#(
  parameter int N_SGI = 16
) (
  input  logic [N_SGI-1:0]   grp,
  input  logic [N_SGI-1:0]   mdf,
  output logic [2*N_SGI-1:0] cls_flat
);

  for (genvar i = 0; i < N_SGI; i++) begin : g_id
    sgi_cls_e c;
    assign c = target_cls(grp[i], mdf[i]);
    assign cls_flat[2*i +: 2] = c;
  end

endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank #(
  parameter int N_SGI = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SGI-1:0] set_vec,
  input  logic [N_SGI-1:0] clr_vec,
  output logic [N_SGI-1:0] pend
);

  for (genvar i = 0; i < N_SGI; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pend[i] <= 1'b0;
      else if (set_vec[i]) pend[i] <= 1'b1;   // set has priority
      else if (clr_vec[i]) pend[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/sgi_group_filter.sv
module sgi_group_filter
  import sgi_filt_pkg::*;
#(
  parameter int N_SGI = 16,
  localparam int ID_W = $clog2(N_SGI)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_ns,
  input  logic [ID_W-1:0]  req_intid,
  input  logic [N_SGI-1:0] cfg_grp,
  input  logic [N_SGI-1:0] cfg_mod,
  input  logic [N_SGI-1:0] clr,
  output logic [N_SGI-1:0] pend,
  output logic             drop_pulse,
  output logic [ID_W-1:0]  drop_intid
);

  sgi_cls_e           snd_cls;
  logic [N_SGI-1:0]   id_vec;
  logic [2*N_SGI-1:0] tgt_flat;
  sgi_cls_e           tgt_cls;
  logic               acc_hit;
  logic               rej_hit;
  logic [N_SGI-1:0]   acc_vec;

  sgi_req_decode #(.N_SGI(N_SGI)) u_req (
    .kind(req_kind), .ns(req_ns), .intid(req_intid),
    .cls(snd_cls), .id_vec(id_vec)
  );

  sgi_cfg_decode #(.N_SGI(N_SGI)) u_cfg (
    .grp(cfg_grp), .mdf(cfg_mod), .cls_flat(tgt_flat)
  );

  always_comb begin
    tgt_cls = sgi_cls_e'(tgt_flat[2*req_intid +: 2]);
    acc_hit = req_valid && (snd_cls != CLS_NONE) && (snd_cls == tgt_cls);
    rej_hit = req_valid && !acc_hit;
    acc_vec = acc_hit ? id_vec : '0;
  end

  sgi_pend_bank #(.N_SGI(N_SGI)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(acc_vec), .clr_vec(clr), .pend(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drop_pulse <= 1'b0;
      drop_intid <= '0;
    end else begin
      drop_pulse <= rej_hit;
      drop_intid <= rej_hit ? req_intid : '0;
    end
  end

endmodule

// File: rtl/sgi_group_filter_chk.sv
module sgi_group_filter_chk #(
  parameter int N_SGI = 16,
  parameter int ID_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [ID_W-1:0]  req_intid,
  input logic [N_SGI-1:0] clr,
  input logic [N_SGI-1:0] pend,
  input logic             drop_pulse,
  input logic [ID_W-1:0]  drop_intid,
  input logic             acc_hit,
  input logic [N_SGI-1:0] acc_vec
);

  AST_ACC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> pend[$past(req_intid)]);                                          // R4
  AST_REJ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_hit) |=> (drop_pulse && drop_intid == $past(req_intid)));   // R5
  AST_QUIET_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !acc_hit) |=> (!drop_pulse && drop_intid == '0));               // R6
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_vec));                                                           // R4
  AST_NO_STRAY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(acc_vec)) == '0));                             // R5
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & $past(clr) & ~$past(acc_vec)) == '0));                               // R7

endmodule

bind sgi_group_filter sgi_group_filter_chk #(.N_SGI(N_SGI), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_intid(req_intid),
  .clr(clr), .pend(pend), .drop_pulse(drop_pulse), .drop_intid(drop_intid),
  .acc_hit(acc_hit), .acc_vec(acc_vec)
);

// File: tb/sim_sgi_group_filter.sv
module sim_sgi_group_filter;
  localparam int PERIOD = 10;
  localparam int N = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = '0;
  logic req_ns = 1'b0;
  logic [IW-1:0] req_intid = '0;
  logic [N-1:0] cfg_grp = '0, cfg_mod = '0, clr = '0;
  logic [N-1:0] pend;
  logic drop_pulse;
  logic [IW-1:0] drop_intid;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [N-1:0] m_pend = '0;

  always #(PERIOD/2) clk = ~clk;

  sgi_group_filter u0 (.*);

  // Acceptance: same Group-1-ness, and for Group 1 the same security side.
  function automatic bit accepts(input logic [1:0] k, input logic ns, input logic g, input logic m);
    bit s_g1, s_sec, r_g1, r_sec;
    if (k == 2'b11) return 0;
    s_g1  = (k != 2'b00);
    s_sec = (k == 2'b01) ? !ns : ns;
    r_g1  = g | m;
    r_sec = m & ~g;
    return (s_g1 == r_g1) && (!s_g1 || s_sec == r_sec);
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] ep, input bit ed, input logic [IW-1:0] ei);
    total++;
    if (pend !== ep || drop_pulse !== ed || drop_intid !== ei) begin
      bad++;
      $display("FAIL %s: pend=%h drop=%b id=%0d expected pend=%h drop=%b id=%0d",
               tag, pend, drop_pulse, drop_intid, ep, ed, ei);
    end
  endtask

  // Called at a negedge: drive one cycle, then check at the next negedge.
  task automatic cyc(input string tag, input bit v, input logic [1:0] k, input logic ns,
                     input logic [IW-1:0] id, input logic [N-1:0] c);
    bit acc, ed;
    logic [IW-1:0] ei;
    req_valid = v; req_kind = k; req_ns = ns; req_intid = id; clr = c;
    acc = v && accepts(k, ns, cfg_grp[id], cfg_mod[id]);
    ed  = v && !acc;
    ei  = ed ? id : '0;
    m_pend = m_pend & ~c;
    if (acc) m_pend[id] = 1'b1;
    @(negedge clk);
    chk(tag, m_pend, ed, ei);
  endtask

  task automatic idle(input string tag);
    cyc(tag, 0, 2'b00, 0, '0, '0);
  endtask

  initial begin
    #(PERIOD*150000);
    bad++;
    $display("FAIL watchdog: expired, expected completion");
    if (!finished) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 in reset", '0, 0, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", '0, 0, '0);

    // R2 / R3: SGI 3 as Secure Group 1
    cfg_grp = '0; cfg_mod = '0; cfg_mod[3] = 1'b1;
    cyc("R2 G0 vs SG1 drops", 1, 2'b00, 0, 4'd3, '0);
    cyc("R2 own G1 from NS drops", 1, 2'b01, 1, 4'd3, '0);
    cyc("R2 own G1 from S accepted", 1, 2'b01, 0, 4'd3, '0);
    cyc("R7 clear", 0, 2'b00, 0, '0, 16'h0008);
    cyc("R2 alt G1 from NS accepted", 1, 2'b10, 1, 4'd3, '0);
    cyc("R10 repeat pending", 1, 2'b10, 1, 4'd3, '0);
    cyc("R2 reserved kind drops", 1, 2'b11, 0, 4'd5, '0);
    idle("R6 quiet after drop");
    // R3: reserved config 11 acts as NS Group 1
    cfg_grp[9] = 1'b1; cfg_mod[9] = 1'b1;
    cyc("R3 reserved cfg takes NS G1", 1, 2'b01, 1, 4'd9, '0);
    cyc("R3 reserved cfg rejects S G1", 1, 2'b10, 1, 4'd9, '0);
    // R5: G0 against NS Group 1 target
    cyc("R5 G0 to NSG1 drops", 1, 2'b00, 0, 4'd9, '0);
    // R9: SGI 0 Group 0, SGI 15 NS Group 1
    cfg_grp[15] = 1'b1;
    cyc("R9 G0 on SGI0 accepted", 1, 2'b00, 1, 4'd0, '0);
    cyc("R9 G0 on SGI15 drops", 1, 2'b00, 1, 4'd15, '0);
    cyc("R9 NS G1 on SGI15 accepted", 1, 2'b01, 1, 4'd15, '0);
    // R8: set and clear on the same SGI in one cycle
    cyc("R8 set beats clear", 1, 2'b00, 0, 4'd0, 16'h0001);
    // R7: clear of a non-pending bit
    cyc("R7 clear idle bit", 0, 2'b00, 0, '0, 16'h0040);
    cyc("R7 clear all", 0, 2'b00, 0, '0, 16'hFFFF);

    // Constrained random mix: R4 R5 R8 coverage
    for (int n = 0; n < 600; n++) begin
      logic [N-1:0] c;
      logic [IW-1:0] id;
      if (n % 40 == 0) begin
        cfg_grp = N'($urandom);
        cfg_mod = N'($urandom);
      end
      id = IW'($urandom);
      c = (($urandom % 3) == 0) ? (N'($urandom) & N'($urandom)) : '0;
      if (($urandom % 5) == 0) c[id] = 1'b1;
      cyc("R4/R5 random", ($urandom % 4) != 0, 2'($urandom), 1'($urandom), id, c);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule